// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands over several clock cycles and returns a 64-bit product. It needs only one 32-bit adder. The multiplier operand sits in the low half of a 64-bit product register. Each cycle, the bit at the bottom of that register decides whether the multiplicand is added into the upper half. The whole register then moves one place to the right, so product bits fill the space that multiplier bits leave.

A caller drives both operands and pulses `start` while the unit is not busy. `busy` then stays high for the 32 iteration cycles. `done` is high for exactly one cycle when the product is ready. The result comes out as a high word and a low word, and it holds until the next accepted start. The unit has no overflow flag. For unsigned operands the product fits in 32 bits exactly when the high word is zero.

The controller has three states:
- `ST_IDLE`: waiting. A start moves it to `ST_RUN` (the load transition).
- `ST_RUN`: one iteration per clock. After the last iteration it moves to `ST_DONE` (the finish transition).
- `ST_DONE`: the result is presented. It returns to `ST_IDLE` unless a new start arrives, which takes it straight to `ST_RUN` (the restart transition).

A synchronous reset returns the controller to `ST_IDLE` from any state.

Top module: `shift_add_mul`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the product to zero and leaves busy and done low.
- R2: Start high at an edge while busy is low is accepted: the operands are captured at that edge and busy is high in the following cycle.
- R3: When done is high, {prod_hi, prod_lo} equals the unsigned 64-bit product of the multiplicand and multiplier captured at the accepting edge.
- R4: done goes high after the 32nd clock edge that follows the accepting edge, and busy is high throughout those 32 cycles.
- R5: done is high for exactly one cycle per operation, and busy and done are never high together.
- R6: Start and operand changes while busy is high are ignored: the running result, its timing and the count of done pulses are unchanged.
- R7: While busy is low and no start is given, prod_hi and prod_lo hold their value.
- R8: A start given in the cycle where done is high is accepted, so operations run back to back.
- R9: The carry out of the 32-bit addition is kept as the top product bit, so 0xFFFFFFFF x 0xFFFFFFFF yields prod_hi 0xFFFFFFFE and prod_lo 0x00000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | 32 | Multiplicand operand |
| mplier | input | 32 | Multiplier operand |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: product valid |
| prod_hi | output | 32 | Upper 32 bits of the product |
| prod_lo | output | 32 | Lower 32 bits of the product |

## Verification
The start is driven on a falling edge, so the next rising edge is the accepting edge. The result is due in the cycle after the 32nd rising edge that follows it, which is 33 cycle counts after the drive. The monitor samples on falling edges. It pops the expected product and the drive cycle from the scoreboard only when done is seen, and it checks both the value and that exact gap. The hold and reset checks read the outputs several cycles after their stimulus. An unexpected extra done finds the queue empty and is reported.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_t;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         en,
    output logic [W:0]   sum
);
    logic [W:0]   carry;
    logic [W-1:0] b_g;

    assign b_g      = b & {W{en}};
    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b_g[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_g[i]) | (carry[i] & (a[i] ^ b_g[i]));
    end

    assign sum[W] = carry[W];
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_t state_q, state_d;
    logic [CW-1:0] iter_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)       iter_q <= '0;
        else if (load) iter_q <= '0;
        else if (step) iter_q <= iter_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (iter_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN:  begin step = 1'b1; busy = 1'b1; end
            ST_DONE: begin done = 1'b1; load = start; end
            default: ;
        endcase
    end
endmodule

// File: rtl/mul_path.sv
module mul_path #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] prod_q;
    logic [W:0]    upper_sum;

    mul_adder #(.W(W)) u_add (
        .a   (prod_q[PW-1:W]),
        .b   (mcand_q),
        .en  (prod_q[0]),
        .sum (upper_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= {upper_sum, prod_q[W-1:1]};
        end
    end

    assign prod = prod_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo
);
    localparam int PW = 2 * W;

    logic          load, step;
    logic [PW-1:0] prod;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_path #(.W(W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .prod      (prod)
    );

    assign prod_hi = prod[PW-1:W];
    assign prod_lo = prod[W-1:0];
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] mcand,
    input logic [W-1:0] mplier,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo
);
    localparam int PW = 2 * W;
    localparam int NW = $clog2(W) + 1;

    logic [NW-1:0] run_n;
    logic [W-1:0]  cap_a, cap_b;
    logic [PW-1:0] golden;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_n <= '0;
            cap_a <= '0;
            cap_b <= '0;
        end else if (start && !busy) begin
            run_n <= '0;
            cap_a <= mcand;
            cap_b <= mplier;
        end else if (busy) begin
            run_n <= run_n + 1'b1;
        end
    end

    assign golden = PW'(cap_a) * PW'(cap_b);

    AST_ACCEPT:     assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);                 // R2
    AST_PRODUCT:    assert property (@(posedge clk) disable iff (rst) done |-> ({prod_hi, prod_lo} == golden));    // R3
    AST_LATENCY:    assert property (@(posedge clk) disable iff (rst) done |-> (run_n == NW'(W)));                 // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done);                             // R5
    AST_EXCLUSIVE:  assert property (@(posedge clk) disable iff (rst) !(busy && done));                            // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst) busy |-> (run_n < NW'(W)));                  // R6
    AST_HOLD:       assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable({prod_hi, prod_lo})); // R7
endmodule

bind shift_add_mul mul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] mcand = '0, mplier = '0;
    logic         busy, done;
    logic [W-1:0] prod_hi, prod_lo;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [2*W-1:0] exp_q[$];
    int             cyc_q[$];
    logic [2*W-1:0] last_exp = '0;

    always #4 clk = ~clk; // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    shift_add_mul #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: wait for not busy, drive start for one cycle, push expectation
    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b);
        while (busy) @(negedge clk);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        exp_q.push_back((2*W)'(a) * (2*W)'(b));
        cyc_q.push_back(cyc);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected done", 64'd1, 64'd0);
            end else begin
                logic [2*W-1:0] e;
                int c0;
                e  = exp_q.pop_front();
                c0 = cyc_q.pop_front();
                last_exp = e;
                check({prod_hi, prod_lo} == e, "R3 product", {prod_hi, prod_lo}, e);
                check(cyc - c0 == 33, "R4 latency", 64'(cyc - c0), 64'd33);
                check(busy == 1'b0, "R5 busy low with done", 64'(busy), 64'd0);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check(!busy && !done && {prod_hi, prod_lo} == 0, "R1 reset state",
                      {prod_hi, prod_lo}, 64'd0);
                rst = 1'b0;

                do_op(32'd0, 32'd0);
                do_op(32'd1, 32'h1234_5678);
                do_op(32'h8765_4321, 32'd1);
                do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9 carry kept
                wait_idle();
                check({prod_hi, prod_lo} == 64'hFFFF_FFFE_0000_0001, "R9 max operands",
                      {prod_hi, prod_lo}, 64'hFFFF_FFFE_0000_0001);
                for (int i = 0; i < W; i += 7) do_op(32'd1 << i, 32'd1 << (W - 1 - i));
                do_op(32'h8000_0000, 32'h8000_0000);
                for (int i = 0; i < 12; i++) do_op($urandom, $urandom);
                wait_idle();

                // R7: hold while idle
                repeat (6) @(negedge clk);
                check({prod_hi, prod_lo} == last_exp, "R7 hold", {prod_hi, prod_lo}, last_exp);

                // R6: start and operand changes during busy are ignored
                do_op(32'hDEAD_BEEF, 32'h0000_1001);
                repeat (4) @(negedge clk);
                mcand = 32'h1111_1111; mplier = 32'h2222_2222; start = 1'b1;
                repeat (3) @(negedge clk);
                start = 1'b0;
                wait_idle();
                repeat (40) @(negedge clk);
                check(exp_q.size() == 0, "R6 no extra result", 64'(exp_q.size()), 64'd0);

                // R8: back-to-back start in the done cycle
                do_op(32'h0001_0003, 32'h0000_0007);
                while (!done) @(negedge clk);
                do_op(32'hABCD_0000, 32'h0000_0100); // R8 accepted while done high
                wait_idle();
                check({prod_hi, prod_lo} == 64'h0000_00AB_CD00_0000, "R8 back-to-back result",
                      {prod_hi, prod_lo}, 64'h0000_00AB_CD00_0000);

                // R1: reset in the middle of a run
                do_op(32'h0F0F_0F0F, 32'hF0F0_F0F0);
                repeat (8) @(negedge clk);
                rst = 1'b1;
                exp_q.delete();
                cyc_q.delete();
                @(negedge clk);
                check(!busy && !done && {prod_hi, prod_lo} == 0, "R1 reset mid-run",
                      {prod_hi, prod_lo}, 64'd0);
                rst = 1'b0;
                repeat (40) @(negedge clk);
                check(!busy && {prod_hi, prod_lo} == 0, "R1 stays idle", {prod_hi, prod_lo}, 64'd0);
            end
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 64'd0, 64'd1);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule